// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the central instruction decoder of a single-cycle load/store datapath. Every cycle it looks at the 6-bit primary opcode of the instruction being executed and at the zero result of the ALU. From these it produces the control lines that steer the datapath: three multiplexer selects, the register-file write enable, the data-memory read and write enables, a branch flag and a 2-bit ALU operation class. It also produces the select that loads the branch target into the program counter.

The block is purely combinational and has no state. Four instruction kinds are recognized: register-register arithmetic (R-type), load word, store word and branch-if-equal. Each kind is found by an exact match on all six opcode bits. Each control line is then the OR of the kinds that assert it. Any other opcode leaves every output low, so an unknown instruction can never write a register or memory. Outputs that the datapath ignores for a given kind are also driven low, which keeps the behaviour fully determined.

There are no states or transitions. The "state" of the block is the set of kinds: NONE, RTYPE, LOAD, STORE and BRANCH. A new opcode moves the block straight from one kind to another within the same cycle.

Top module: `main_ctl_decoder`

## Requirements
- R1: Opcode 000000 (R-type) drives dst_sel_o=1, alu_b_imm_o=0, wb_from_mem_o=0, reg_we_o=1, mem_rd_o=0, mem_wr_o=0, branch_o=0 and alu_class_o=2'b10 (operation taken from the function field).
- R2: Opcode 100011 (load word) drives dst_sel_o=0, alu_b_imm_o=1, wb_from_mem_o=1, reg_we_o=1, mem_rd_o=1, mem_wr_o=0, branch_o=0 and alu_class_o=2'b00 (add).
- R3: Opcode 101011 (store word) drives alu_b_imm_o=1, mem_wr_o=1 and alu_class_o=2'b00. All other lines are 0, including dst_sel_o and wb_from_mem_o, which the datapath ignores for this kind.
- R4: Opcode 000100 (branch if equal) drives branch_o=1 and alu_class_o=2'b01 (subtract). All other lines are 0, including dst_sel_o and wb_from_mem_o, which the datapath ignores for this kind.
- R5: pc_branch_sel_o is 1 exactly when branch_o is 1 and alu_zero_i is 1. Otherwise it is 0, and the PC takes PC+4.
- R6: Each of the other 60 opcode values drives all nine control lines and pc_branch_sel_o to 0.
- R7: mem_rd_o and mem_wr_o are never 1 together. When mem_rd_o is 1, both reg_we_o and wb_from_mem_o are 1.
- R8: For any given opcode, every output other than pc_branch_sel_o is the same for alu_zero_i=0 and alu_zero_i=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field of the current instruction |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| dst_sel_o | output | 1 | 1: write destination is rd; 0: write destination is rt |
| alu_b_imm_o | output | 1 | 1: second ALU operand is the immediate; 0: second ALU operand is the register |
| wb_from_mem_o | output | 1 | 1: write-back data comes from memory; 0: write-back data comes from the ALU |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Data-memory read enable |
| mem_wr_o | output | 1 | Data-memory write enable |
| branch_o | output | 1 | Instruction is a conditional branch |
| alu_class_o | output | 2 | 00 add, 01 subtract, 10 use function field |
| pc_branch_sel_o | output | 1 | Load the branch target into the PC |

## Verification
The hardest case to reach is the one where the branch flag and the zero flag must line up. The PC select must rise only for the branch opcode combined with zero=1, and never for an opcode that merely shares bits with a supported one. Near-miss opcodes such as 100010 or 000101 differ from a supported code in one bit, and only they show whether the match really covers all six bits. The bench therefore sweeps all 64 opcodes twice, once with zero low and once with zero high. It also compares the two passes to show that the zero flag reaches nothing but the PC select.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    localparam int OPC_W     = 6;
    localparam int NUM_KINDS = 4;
    localparam int ALU_CLS_W = 2;

    // supported instruction kinds; index order is the one-hot match order
    typedef enum logic [1:0] {
        KIND_RTYPE  = 2'd0,
        KIND_LOAD   = 2'd1,
        KIND_STORE  = 2'd2,
        KIND_BRANCH = 2'd3
    } insn_kind_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;

    localparam logic [ALU_CLS_W-1:0] ALU_ADD   = 2'b00;
    localparam logic [ALU_CLS_W-1:0] ALU_SUB   = 2'b01;
    localparam logic [ALU_CLS_W-1:0] ALU_FIELD = 2'b10;

    typedef struct packed {
        logic                 dst_sel;
        logic                 alu_b_imm;
        logic                 wb_from_mem;
        logic                 reg_we;
        logic                 mem_rd;
        logic                 mem_wr;
        logic                 branch;
        logic [ALU_CLS_W-1:0] alu_class;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    function automatic logic [OPC_W-1:0] kind_opcode(input int k);
        case (k)
            0:       kind_opcode = OPC_RTYPE;
            1:       kind_opcode = OPC_LOAD;
            2:       kind_opcode = OPC_STORE;
            default: kind_opcode = OPC_BRANCH;
        endcase
    endfunction

    // one row of the OR plane; ignored lines are held at 0
    function automatic ctl_word_t kind_row(input int k);
        ctl_word_t r;
        r = '0;
        case (k)
            0: begin
                r.dst_sel   = 1'b1;
                r.reg_we    = 1'b1;
                r.alu_class = ALU_FIELD;
            end
            1: begin
                r.alu_b_imm   = 1'b1;
                r.wb_from_mem = 1'b1;
                r.reg_we      = 1'b1;
                r.mem_rd      = 1'b1;
                r.alu_class   = ALU_ADD;
            end
            2: begin
                r.alu_b_imm = 1'b1;
                r.mem_wr    = 1'b1;
                r.alu_class = ALU_ADD;
            end
            default: begin
                r.branch    = 1'b1;
                r.alu_class = ALU_SUB;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mcd_opcode_match.sv
module mcd_opcode_match
    import mcd_pkg::*;
#(
    parameter int OW = OPC_W,
    parameter int NK = NUM_KINDS
) (
    input  logic [OW-1:0] opcode_i,
    output logic [NK-1:0] hit_o
);

    // one AND term per kind, every opcode bit compared
    for (genvar k = 0; k < NK; k++) begin : g_term
        localparam logic [OW-1:0] CODE = OW'(kind_opcode(k));
        assign hit_o[k] = &(opcode_i ~^ CODE);
    end

endmodule

// File: rtl/mcd_or_plane.sv
module mcd_or_plane
    import mcd_pkg::*;
#(
    parameter int NK = NUM_KINDS
) (
    input  logic [NK-1:0] hit_i,
    output ctl_word_t     ctl_o
);

    // each output bit is the OR of the kind terms whose row sets it
    for (genvar b = 0; b < CTL_W; b++) begin : g_bit
        logic [NK-1:0] sel;
        for (genvar k = 0; k < NK; k++) begin : g_kind
            localparam ctl_word_t ROW = kind_row(k);
            assign sel[k] = hit_i[k] & ROW[b];
        end
        assign ctl_o[b] = |sel;
    end

endmodule

// File: rtl/mcd_pc_gate.sv
module mcd_pc_gate (
    input  logic branch_i,
    input  logic zero_i,
    output logic take_o
);

    assign take_o = branch_i & zero_i;

endmodule

// File: rtl/main_ctl_decoder.sv
module main_ctl_decoder
    import mcd_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic       alu_zero_i,
    output logic       dst_sel_o,
    output logic       alu_b_imm_o,
    output logic       wb_from_mem_o,
    output logic       reg_we_o,
    output logic       mem_rd_o,
    output logic       mem_wr_o,
    output logic       branch_o,
    output logic [1:0] alu_class_o,
    output logic       pc_branch_sel_o
);

    logic [NUM_KINDS-1:0] kind_hit;
    ctl_word_t            ctl;

    mcd_opcode_match #(.OW(OPC_W), .NK(NUM_KINDS)) u_match (
        .opcode_i (opcode_i),
        .hit_o    (kind_hit)
    );

    mcd_or_plane #(.NK(NUM_KINDS)) u_plane (
        .hit_i (kind_hit),
        .ctl_o (ctl)
    );

    mcd_pc_gate u_gate (
        .branch_i (ctl.branch),
        .zero_i   (alu_zero_i),
        .take_o   (pc_branch_sel_o)
    );

    assign dst_sel_o     = ctl.dst_sel;
    assign alu_b_imm_o   = ctl.alu_b_imm;
    assign wb_from_mem_o = ctl.wb_from_mem;
    assign reg_we_o      = ctl.reg_we;
    assign mem_rd_o      = ctl.mem_rd;
    assign mem_wr_o      = ctl.mem_wr;
    assign branch_o      = ctl.branch;
    assign alu_class_o   = ctl.alu_class;

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
    input logic [5:0] opcode_i,
    input logic       alu_zero_i,
    input logic       dst_sel_o,
    input logic       alu_b_imm_o,
    input logic       wb_from_mem_o,
    input logic       reg_we_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       branch_o,
    input logic [1:0] alu_class_o,
    input logic       pc_branch_sel_o
);

    logic known;
    assign known = (opcode_i == 6'b000000) || (opcode_i == 6'b100011) ||
                   (opcode_i == 6'b101011) || (opcode_i == 6'b000100);

    always_comb begin
        // R7
        mem_excl_chk: assert (!(mem_rd_o && mem_wr_o))
            else $error("memory read and write both asserted");
        // R7
        load_wb_chk: assert (!mem_rd_o || (reg_we_o && wb_from_mem_o))
            else $error("memory read without memory write-back");
        // R5
        pc_needs_zero_chk: assert (!pc_branch_sel_o || (branch_o && alu_zero_i))
            else $error("PC select without taken branch");
        // R5
        pc_taken_chk: assert (!(branch_o && alu_zero_i) || pc_branch_sel_o)
            else $error("taken branch did not select target");
        // R6
        unknown_quiet_chk: assert (known || ({dst_sel_o, alu_b_imm_o, wb_from_mem_o,
                                  reg_we_o, mem_rd_o, mem_wr_o, branch_o,
                                  alu_class_o, pc_branch_sel_o} == 10'b0))
            else $error("unsupported opcode drove a control line");
        // R4
        branch_only_chk: assert (!branch_o || (opcode_i == 6'b000100))
            else $error("branch flag on a non-branch opcode");
    end

endmodule

bind main_ctl_decoder mcd_checker u_chk (
    .opcode_i        (opcode_i),
    .alu_zero_i      (alu_zero_i),
    .dst_sel_o       (dst_sel_o),
    .alu_b_imm_o     (alu_b_imm_o),
    .wb_from_mem_o   (wb_from_mem_o),
    .reg_we_o        (reg_we_o),
    .mem_rd_o        (mem_rd_o),
    .mem_wr_o        (mem_wr_o),
    .branch_o        (branch_o),
    .alu_class_o     (alu_class_o),
    .pc_branch_sel_o (pc_branch_sel_o)
);

// File: tb/tb_main_ctl_decoder.sv
module tb_main_ctl_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode_i = 6'b111111;
    logic       alu_zero_i = 1'b0;
    logic       dst_sel_o, alu_b_imm_o, wb_from_mem_o, reg_we_o;
    logic       mem_rd_o, mem_wr_o, branch_o, pc_branch_sel_o;
    logic [1:0] alu_class_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [8:0] seen_z0 [64];

    always #10 clk = ~clk;   // 50 MHz

    main_ctl_decoder dut (
        .opcode_i        (opcode_i),
        .alu_zero_i      (alu_zero_i),
        .dst_sel_o       (dst_sel_o),
        .alu_b_imm_o     (alu_b_imm_o),
        .wb_from_mem_o   (wb_from_mem_o),
        .reg_we_o        (reg_we_o),
        .mem_rd_o        (mem_rd_o),
        .mem_wr_o        (mem_wr_o),
        .branch_o        (branch_o),
        .alu_class_o     (alu_class_o),
        .pc_branch_sel_o (pc_branch_sel_o)
    );

    function automatic logic [8:0] lines_now();
        return {dst_sel_o, alu_b_imm_o, wb_from_mem_o, reg_we_o,
                mem_rd_o, mem_wr_o, branch_o, alu_class_o};
    endfunction

    // expected nine lines, {dst,bimm,wbm,we,rd,wr,br,cls[1:0]}
    function automatic logic [8:0] expect_lines(input logic [5:0] op);
        case (op)
            6'b000000: return 9'b1_0_0_1_0_0_0_10;
            6'b100011: return 9'b0_1_1_1_1_0_0_00;
            6'b101011: return 9'b0_1_0_0_0_1_0_00;
            6'b000100: return 9'b0_0_0_0_0_0_1_01;
            default:   return 9'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'b000000: return "R1";
            6'b100011: return "R2";
            6'b101011: return "R3";
            6'b000100: return "R4";
            default:   return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s opcode=%b zero=%0b actual=%b expected=%b",
                     req, opcode_i, alu_zero_i, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic z);
        @(negedge clk);
        opcode_i   = op;
        alu_zero_i = z;
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: unsupported opcode, all quiet (R6)
        apply(6'b111111, 1'b1);
        check("R6", {lines_now(), pc_branch_sel_o}, 10'b0);

        for (int z = 0; z < 2; z++) begin
            for (int op = 0; op < 64; op++) begin
                logic [8:0] e;
                logic       ep;
                apply(op[5:0], z[0]);
                e  = expect_lines(op[5:0]);
                ep = e[2] & z[0];
                check(req_of(op[5:0]), {lines_now(), 1'b0}, {e, 1'b0});
                check("R5", {9'b0, pc_branch_sel_o}, {9'b0, ep});
                check("R7", {8'b0, mem_rd_o & mem_wr_o, mem_rd_o & ~(reg_we_o & wb_from_mem_o)}, 10'b0);
                if (z == 0) seen_z0[op] = lines_now();
                else        check("R8", {lines_now(), 1'b0}, {seen_z0[op], 1'b0});
            end
        end

        // branch toggling zero on a held opcode (R5)
        apply(6'b000100, 1'b0);
        check("R5", {9'b0, pc_branch_sel_o}, 10'b0);
        apply(6'b000100, 1'b1);
        check("R5", {9'b0, pc_branch_sel_o}, 10'b1);
        // one-bit neighbours of branch never take (R6)
        apply(6'b000101, 1'b1);
        check("R6", {lines_now(), pc_branch_sel_o}, 10'b0);
        apply(6'b001100, 1'b1);
        check("R6", {lines_now(), pc_branch_sel_o}, 10'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule